// File: doc/BRIEF.md
# Packet-Filter VM ALU Execute Unit

This block is the arithmetic execute stage of a 64-bit register-machine virtual CPU used for packet filtering. It holds eleven general registers: r0 to r9, plus r10, which serves as a read-only frame pointer. Each cycle it can accept one decoded ALU instruction. The instruction gives the operand width (64-bit or 32-bit class), a 4-bit operation code, a source selector (signed 32-bit immediate or source register), a destination index and a source index.

The unit reads the destination value and the source value from its register file and computes the result. One clock edge later, it writes the result back and presents it on its output. Two encodings do not write anything:

- a 32-bit, register-source negate is a breakpoint trap;
- any write to the frame pointer, or any other malformed encoding, raises an illegal-instruction flag.

Instruction fetch, memory access, branching and byte swapping are handled elsewhere.

Top module: `pfx_alu_unit`

## Requirements
- R1: After reset, out_valid, out_brk and out_ill are 0 and out_data is 0. Registers r0 to r9 hold 0, and r10 holds the parameter FP_INIT.
- R2: For the 64-bit class (in_is32=0) with an immediate source (in_src_reg=0), the result is dst OP imm, with imm sign-extended to 64 bits. The op codes are: add=0, sub=1, mul=2, div=3, or=4, and=5, lsh=6, rsh=7, neg=8, mod=9, xor=10, mov=11, arsh=12.
- R3: With a register source (in_src_reg=1), the second operand is the register selected by in_src.
- R4: For the 32-bit class (in_is32=1), both operands are taken as unsigned low 32 bits, with the immediate used as its raw 32 bits. The 32-bit result is zero-extended into bits 63:32.
- R5: The shift amount is the low 6 bits of the operand in the 64-bit class and the low 5 bits in the 32-bit class. rsh fills with zeros. arsh copies bit 63 (64-bit class) or bit 31 (32-bit class).
- R6: div and mod are unsigned. Division by zero gives 0. Modulo by zero gives the destination value unchanged at the operating width, so the 32-bit class zero-extends the low half.
- R7: neg gives the two's complement of the destination at the operating width, and ignores the immediate.
- R8: mov writes the selected operand without using the old destination value.
- R9: A 32-bit class, register-source neg raises out_brk for one cycle and writes no register.
- R10: out_ill rises and no register is written in any of these cases:
  - the destination index is 10 or above;
  - a register source with index above 10 is selected;
  - the op code is 13 to 15;
  - a 64-bit class neg has a register source.
- R11: Outputs appear on the clock edge that accepts in_valid and are 0 in cycles with no issue. An instruction issued in the very next cycle reads the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_is32 | input | 1 | 1 selects the 32-bit class |
| in_op | input | 4 | Operation code |
| in_src_reg | input | 1 | 1 selects register source, 0 immediate |
| in_dst | input | 4 | Destination register index |
| in_src | input | 4 | Source register index |
| in_imm | input | 32 | Immediate operand |
| out_valid | output | 1 | A register was written this cycle |
| out_dst | output | 4 | Index written |
| out_data | output | 64 | Value written |
| out_brk | output | 1 | Breakpoint trap |
| out_ill | output | 1 | Illegal instruction |

## Verification
A corrupted register shows up at the ports only when a later instruction reads it. To keep that delay short, the bench compares every write-back against a register model, so a wrong value surfaces within one or two instructions. Rejected writes (breakpoint, frame-pointer target) are proven by reading the affected register back with a mov in the following cycle. Width errors in the 32-bit class appear at once as nonzero upper bits. Shift-mask and zero-divisor mistakes appear in the first result that exercises them.

// File: rtl/pfx_alu_pkg.sv
// Shared operation codes and widths for the packet-filter ALU unit.
// Assumes a 4-bit operation field decoded by an earlier stage.
package pfx_alu_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_OR   = 4'd4,
        OP_AND  = 4'd5,
        OP_LSH  = 4'd6,
        OP_RSH  = 4'd7,
        OP_NEG  = 4'd8,
        OP_MOD  = 4'd9,
        OP_XOR  = 4'd10,
        OP_MOV  = 4'd11,
        OP_ARSH = 4'd12
    } alu_op_e;

    localparam logic [OPW-1:0] OP_LAST = 4'd12;
endpackage

// File: rtl/pfx_regfile.sv
// Register file: NREG entries, two combinational read ports, one write port.
// The last entry is the frame pointer; it is a constant FP_INIT and can
// never be written. Reads of indices at or beyond NREG return zero.
module pfx_regfile #(
    parameter int          XLEN    = 64,
    parameter int          NREG    = 11,
    parameter int          IDXW    = 4,
    parameter logic [63:0] FP_INIT = 64'h200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IDXW-1:0] rd_a_idx,
    output logic [XLEN-1:0] rd_a,
    input  logic [IDXW-1:0] rd_b_idx,
    output logic [XLEN-1:0] rd_b
);
    localparam int FP_IDX = NREG - 1;
    localparam logic [IDXW-1:0] FP_SEL = IDXW'(FP_IDX);

    logic [XLEN-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == FP_IDX) begin : g_fp
            // Frame pointer: fixed value, no write path.
            assign regs[i] = FP_INIT[XLEN-1:0];
        end else begin : g_gpr
            // General register: clear on reset, load on matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (wr_en && wr_idx == IDXW'(i))
                    regs[i] <= wr_data;
            end
        end
    end

    // Read port A: guarded against indices past the file.
    always_comb rd_a = (32'(rd_a_idx) < NREG) ? regs[rd_a_idx] : '0;
    // Read port B: guarded against indices past the file.
    always_comb rd_b = (32'(rd_b_idx) < NREG) ? regs[rd_b_idx] : '0;

    // R10
    wr_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < FP_SEL));
endmodule

// File: rtl/pfx_alu_core.sv
// Combinational ALU core. It computes a 64-bit and a 32-bit result for the
// operation and picks one by class; the 32-bit result is zero-extended.
// Assumes operand b was already selected and extended by the caller.
module pfx_alu_core
    import pfx_alu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic            is32,
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] result
);
    localparam int SHW_W = $clog2(XLEN);
    localparam int SHW_H = $clog2(HALF);

    logic [HALF-1:0]  a_h, b_h, r_h;
    logic [XLEN-1:0]  r_w;
    logic [SHW_W-1:0] sh_w;
    logic [SHW_H-1:0] sh_h;

    // Operation select at both widths.
    always_comb begin
        a_h  = a[HALF-1:0];
        b_h  = b[HALF-1:0];
        sh_w = b[SHW_W-1:0];
        sh_h = b[SHW_H-1:0];
        r_w  = '0;
        r_h  = '0;
        case (op)
            OP_ADD:  begin r_w = a + b;  r_h = a_h + b_h; end
            OP_SUB:  begin r_w = a - b;  r_h = a_h - b_h; end
            OP_MUL:  begin r_w = a * b;  r_h = a_h * b_h; end
            OP_DIV:  begin
                r_w = (b == '0)   ? '0 : a / b;
                r_h = (b_h == '0) ? '0 : a_h / b_h;
            end
            OP_MOD:  begin
                r_w = (b == '0)   ? a   : a % b;
                r_h = (b_h == '0) ? a_h : a_h % b_h;
            end
            OP_OR:   begin r_w = a | b;  r_h = a_h | b_h; end
            OP_AND:  begin r_w = a & b;  r_h = a_h & b_h; end
            OP_XOR:  begin r_w = a ^ b;  r_h = a_h ^ b_h; end
            OP_LSH:  begin r_w = a << sh_w; r_h = a_h << sh_h; end
            OP_RSH:  begin r_w = a >> sh_w; r_h = a_h >> sh_h; end
            OP_ARSH: begin
                r_w = $unsigned($signed(a) >>> sh_w);
                r_h = $unsigned($signed(a_h) >>> sh_h);
            end
            OP_NEG:  begin r_w = -a; r_h = -a_h; end
            OP_MOV:  begin r_w = b;  r_h = b_h; end
            default: begin r_w = '0; r_h = '0; end
        endcase
    end

    // Width select with zero extension for the 32-bit class.
    always_comb result = is32 ? {{(XLEN-HALF){1'b0}}, r_h} : r_w;
endmodule

// File: rtl/pfx_decode.sv
// Legality decode. It classifies an instruction as a breakpoint, as illegal,
// or as a register write. Assumes the frame pointer is the last register.
module pfx_decode
    import pfx_alu_pkg::*;
#(
    parameter int NREG = 11,
    parameter int IDXW = 4
) (
    input  logic            is32,
    input  logic [OPW-1:0]  op,
    input  logic            src_reg,
    input  logic [IDXW-1:0] dst,
    input  logic [IDXW-1:0] src,
    output logic            brk,
    output logic            ill,
    output logic            wr
);
    localparam logic [IDXW-1:0] FP_SEL = IDXW'(NREG - 1);

    // The breakpoint takes priority; otherwise collect the illegal cases.
    always_comb begin
        brk = is32 && src_reg && (op == OP_NEG);
        ill = !brk && ((op > OP_LAST) || (dst >= FP_SEL) ||
                       (src_reg && src > FP_SEL) ||
                       (op == OP_NEG && src_reg));
        wr  = !brk && !ill;
    end
endmodule

// File: rtl/pfx_alu_unit.sv
// Top of the packet-filter ALU execute unit. It reads operands from the
// register file, selects and extends the second operand, computes the
// result and, on one clock edge, writes back and registers the outputs.
// Assumes in_* are stable across the capturing edge.
module pfx_alu_unit
    import pfx_alu_pkg::*;
#(
    parameter int          XLEN    = 64,
    parameter int          HALF    = 32,
    parameter int          NREG    = 11,
    parameter int          IDXW    = 4,
    parameter logic [63:0] FP_INIT = 64'h200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_is32,
    input  logic [3:0]      in_op,
    input  logic            in_src_reg,
    input  logic [IDXW-1:0] in_dst,
    input  logic [IDXW-1:0] in_src,
    input  logic [HALF-1:0] in_imm,
    output logic            out_valid,
    output logic [IDXW-1:0] out_dst,
    output logic [XLEN-1:0] out_data,
    output logic            out_brk,
    output logic            out_ill
);
    logic [XLEN-1:0] dst_val, src_val, opnd_b, alu_res;
    logic            dec_brk, dec_ill, dec_wr, do_wr;

    pfx_regfile #(.XLEN(XLEN), .NREG(NREG), .IDXW(IDXW), .FP_INIT(FP_INIT)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(do_wr), .wr_idx(in_dst), .wr_data(alu_res),
        .rd_a_idx(in_dst), .rd_a(dst_val),
        .rd_b_idx(in_src), .rd_b(src_val)
    );

    pfx_decode #(.NREG(NREG), .IDXW(IDXW)) u_dec (
        .is32(in_is32), .op(in_op), .src_reg(in_src_reg),
        .dst(in_dst), .src(in_src),
        .brk(dec_brk), .ill(dec_ill), .wr(dec_wr)
    );

    // Second operand: register, or immediate extended by class.
    always_comb begin
        if (in_src_reg)
            opnd_b = src_val;
        else if (in_is32)
            opnd_b = {{(XLEN-HALF){1'b0}}, in_imm};
        else
            opnd_b = {{(XLEN-HALF){in_imm[HALF-1]}}, in_imm};
    end

    pfx_alu_core #(.XLEN(XLEN), .HALF(HALF)) u_core (
        .is32(in_is32), .op(in_op), .a(dst_val), .b(opnd_b), .result(alu_res)
    );

    // Commit only for a valid, legal instruction.
    always_comb do_wr = in_valid && dec_wr;

    // Output register: write-back report and trap flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dst   <= '0;
            out_data  <= '0;
            out_brk   <= 1'b0;
            out_ill   <= 1'b0;
        end else begin
            out_valid <= do_wr;
            out_dst   <= do_wr ? in_dst : '0;
            out_data  <= do_wr ? alu_res : '0;
            out_brk   <= in_valid && dec_brk;
            out_ill   <= in_valid && dec_ill;
        end
    end

    // R9
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_brk && out_ill));
    // R9
    brk_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_brk |-> $past(in_valid && in_is32 && in_src_reg && in_op == OP_NEG));
    // R10
    no_fp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dst < IDXW'(NREG - 1)));
    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_is32)) |-> (out_data[XLEN-1:HALF] == '0));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_valid && !out_brk && !out_ill));
endmodule

// File: tb/tb_pfx_alu_unit.sv
module tb_pfx_alu_unit;
    localparam logic [63:0] FPV = 64'h0000_0000_0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_is32 = 1'b0, in_src_reg = 1'b0;
    logic [3:0]  in_op = '0, in_dst = '0, in_src = '0;
    logic [31:0] in_imm = '0;
    logic        out_valid, out_brk, out_ill;
    logic [3:0]  out_dst;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] mreg [11];

    pfx_alu_unit #(.FP_INIT(FPV)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is32(in_is32),
        .in_op(in_op), .in_src_reg(in_src_reg), .in_dst(in_dst),
        .in_src(in_src), .in_imm(in_imm), .out_valid(out_valid),
        .out_dst(out_dst), .out_data(out_data), .out_brk(out_brk),
        .out_ill(out_ill)
    );

    always #2 clk = ~clk;

    // Reference result, written from the requirement text.
    function automatic logic [63:0] ref_res(bit w32, logic [3:0] op,
                                            logic [63:0] a, logic [63:0] b);
        logic [31:0] x, y, r;
        logic [63:0] q;
        x = a[31:0]; y = b[31:0];
        if (w32) begin
            case (op)
                0: r = x + y;   1: r = x - y;   2: r = x * y;
                3: r = (y != 0) ? x / y : 32'd0;
                4: r = x | y;   5: r = x & y;
                6: r = x << y[4:0];   7: r = x >> y[4:0];
                8: r = 32'd0 - x;
                9: r = (y != 0) ? x % y : x;
                10: r = x ^ y;  11: r = y;
                12: r = 32'($signed(x) >>> y[4:0]);
                default: r = 32'd0;
            endcase
            return {32'd0, r};
        end
        case (op)
            0: q = a + b;   1: q = a - b;   2: q = a * b;
            3: q = (b != 0) ? a / b : 64'd0;
            4: q = a | b;   5: q = a & b;
            6: q = a << b[5:0];   7: q = a >> b[5:0];
            8: q = 64'd0 - a;
            9: q = (b != 0) ? a % b : a;
            10: q = a ^ b;  11: q = b;
            12: q = 64'($signed(a) >>> b[5:0]);
            default: q = 64'd0;
        endcase
        return q;
    endfunction

    // Issue one instruction (caller is at a falling edge), check one cycle later.
    task automatic run(string tag, bit w32, logic [3:0] op, bit sreg,
                       logic [3:0] d, logic [3:0] s, logic [31:0] imm);
        logic [63:0] a, sv, b, er;
        bit eb, ei, ew;
        a  = (d <= 10) ? mreg[d] : 64'd0;
        sv = (s <= 10) ? mreg[s] : 64'd0;
        b  = sreg ? sv : (w32 ? {32'd0, imm} : {{32{imm[31]}}, imm});
        eb = w32 && sreg && op == 4'd8;
        ei = !eb && (op > 12 || d >= 10 || (sreg && s > 10) || (op == 4'd8 && sreg));
        ew = !eb && !ei;
        er = ew ? ref_res(w32, op, a, b) : 64'd0;
        in_valid = 1'b1; in_is32 = w32; in_op = op; in_src_reg = sreg;
        in_dst = d; in_src = s; in_imm = imm;
        @(negedge clk);
        checks++;
        if (out_valid !== ew || out_data !== er || out_brk !== eb ||
            out_ill !== ei || (ew && out_dst !== d)) begin
            errors++;
            $display("FAIL %s: valid/dst/data/brk/ill = %0b/%0d/%h/%0b/%0b expected %0b/%0d/%h/%0b/%0b",
                     tag, out_valid, out_dst, out_data, out_brk, out_ill,
                     ew, d, er, eb, ei);
        end
        if (ew) mreg[d] = er;
    endtask

    task automatic idle_check(string tag);
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_brk !== 1'b0 || out_ill !== 1'b0 ||
            out_data !== 64'd0) begin
            errors++;
            $display("FAIL %s: idle outputs valid/brk/ill/data = %0b/%0b/%0b/%h expected 0/0/0/0",
                     tag, out_valid, out_brk, out_ill, out_data);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 10; i++) mreg[i] = 64'd0;
        mreg[10] = FPV;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_check("R1 reset outputs");
        run("R1 fp reset value", 0, 11, 1, 1, 10, 0);
        run("R1 gpr reset zero", 0, 11, 1, 2, 7, 0);
        run("R2 mov sign-extended imm", 0, 11, 0, 1, 0, 32'hFFFF_FFF0);
        run("R2 add imm", 0, 0, 0, 1, 0, 32'h20);
        run("R2 sub negative imm", 0, 1, 0, 1, 0, 32'hFFFF_FFFF);
        run("R2 mul imm", 0, 2, 0, 1, 0, 32'd3);
        run("R8 mov imm ignores dst", 0, 11, 0, 2, 0, 32'd5);
        run("R3 add reg source", 0, 0, 1, 1, 2, 32'h1234);
        run("R3 xor reg source", 0, 10, 1, 1, 2, 0);
        run("R8 mov reg ignores dst", 0, 11, 1, 3, 1, 0);
        run("R4 set all ones", 0, 11, 0, 3, 0, 32'hFFFF_FFFF);
        run("R4 add32 wraps and zero-extends", 1, 0, 0, 3, 0, 32'd1);
        run("R4 mov32 imm not sign-extended", 1, 11, 0, 4, 0, 32'h8000_0000);
        run("R5 set one", 0, 11, 0, 5, 0, 32'd1);
        run("R5 lsh64 masked 65", 0, 6, 0, 5, 0, 32'd65);
        run("R5 lsh32 masked 33", 1, 6, 0, 5, 0, 32'd33);
        run("R5 arsh32 sign of bit31", 1, 12, 0, 4, 0, 32'd4);
        run("R5 set neg", 0, 11, 0, 6, 0, 32'hFFFF_FFFF);
        run("R5 arsh64 keeps ones", 0, 12, 0, 6, 0, 32'd63);
        run("R5 rsh64 zero fill", 0, 7, 0, 6, 0, 32'd60);
        run("R5 set neg again", 0, 11, 0, 6, 0, 32'hFFFF_FFFF);
        run("R5 rsh32 zero fill", 1, 7, 0, 6, 0, 32'd28);
        run("R6 set 100", 0, 11, 0, 7, 0, 32'd100);
        run("R6 div64 by 7", 0, 3, 0, 7, 0, 32'd7);
        run("R6 mod64 by 5", 0, 9, 0, 7, 0, 32'd5);
        run("R6 set 100", 0, 11, 0, 7, 0, 32'd100);
        run("R6 mod64 by zero keeps dst", 0, 9, 0, 7, 0, 32'd0);
        run("R6 div64 by zero gives 0", 0, 3, 0, 7, 0, 32'd0);
        run("R6 set all ones", 0, 11, 0, 3, 0, 32'hFFFF_FFFF);
        run("R6 mod32 by zero zero-extends", 1, 9, 0, 3, 0, 32'd0);
        run("R6 div by neg imm unsigned", 0, 3, 0, 6, 0, 32'hFFFF_FFFE);
        run("R7 neg64", 0, 8, 0, 1, 0, 32'hDEAD);
        run("R7 neg32", 1, 8, 0, 1, 0, 32'h0);
        run("R9 breakpoint", 1, 8, 1, 1, 2, 0);
        run("R9 dst untouched after breakpoint", 0, 11, 1, 8, 1, 0);
        run("R10 write to fp rejected", 0, 11, 0, 10, 0, 32'd7);
        run("R10 fp unchanged", 0, 11, 1, 8, 10, 0);
        run("R10 dst 11 rejected", 0, 0, 0, 11, 0, 32'd1);
        run("R10 opcode 13 rejected", 0, 13, 0, 1, 0, 32'd1);
        run("R10 src 12 rejected", 0, 0, 1, 1, 12, 0);
        run("R10 neg64 register source rejected", 0, 8, 1, 1, 2, 0);
        run("R11 back-to-back first", 0, 0, 0, 9, 0, 32'd1);
        run("R11 back-to-back reads new value", 0, 0, 1, 9, 9, 0);
        idle_check("R11 no issue no output");
        for (int k = 0; k < 600; k++) begin
            logic [3:0] rop, rd, rs;
            logic [31:0] rim;
            rop = 4'($urandom_range(0, 15));
            rd  = 4'($urandom_range(0, 10));
            rs  = 4'($urandom_range(0, 10));
            rim = $urandom();
            if (($urandom() & 3) == 0) rim = 32'($urandom_range(0, 70));
            run("R2 R3 R4 random", bit'($urandom_range(0, 1)), rop,
                bit'($urandom_range(0, 1)), rd, rs, rim);
        end
        idle_check("R11 final idle");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule